// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is an SPI master that runs one short flash transaction per start command. A host writes a command byte, up to three address bytes and one data byte into byte registers on a small register port with 3-bit offsets. It then writes a control byte that carries a start key, a write-length code and a read count. The engine shifts the selected bytes out in SPI mode 0, most significant bit first. It then clocks in up to three reply bytes and stores them in registers the host can read.

The write length is not a plain count. A two-bit code selects 1, 2, 4 or 5 bytes. The three address bytes are held in registers in the opposite order to the one they take on the wire: offset 4 goes out first and offset 2 last. Offset 7 is shared. A write to it loads the extra data byte, and a read from it returns the third received byte. The whole frame is copied into the shifter when the start is accepted, so the host may rewrite registers while a transaction is running.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0 and mosi is 0, and a read at every offset 0 to 7 returns 0x00.
- R2: A write to offset 0 whose bits 7:4 equal 0x5, made while idle, starts a transaction. From the next cycle until the transaction ends, offset 0 reads with bit 7 set. A write to offset 0 with any other value in bits 7:4 starts nothing.
- R3: Control bits 1:0 select the number of bytes sent: code 0 sends 1 byte, code 1 sends 2, code 2 sends 4 and code 3 sends 5.
- R4: The byte at offset 1 is always the first byte on mosi.
- R5: For codes 2 and 3, the bytes after the command byte come from offset 4, then offset 3, then offset 2.
- R6: For code 1, the second byte sent comes from offset 7. For code 3, offset 7 is sent last, after the address bytes.
- R7: Control bits 3:2 give the number of bytes received, 0 to 3. Received bytes land at offsets 5, 6 and 7 in order of arrival. Receive registers that the transaction does not fill keep their earlier values.
- R8: The bus runs in mode 0. sclk idles low, and each sclk phase lasts HALF_DIV clocks. mosi changes only while sclk is low, and the first bit is presented together with the falling edge of cs_n. miso is sampled when sclk rises. Bits travel most significant first.
- R9: cs_n falls in the cycle after the start is accepted. It rises at the falling sclk edge that ends the last bit. The read phase follows the write phase with no gap, so exactly 8 x (bytes sent + bytes received) rising sclk edges occur.
- R10: A start written while busy is ignored. Register writes made during a transaction change the registers but not the bytes being shifted.
- R11: Offset 0 reads as {busy, 3'b000, bits 3:0 of the last accepted start}. Writes to offsets 5 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for the current cycle |
| reg_ofs | input | 3 | Register offset, shared by reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_ofs (combinational) |
| miso | input | 1 | Serial data from the flash device |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the flash device |
| cs_n | output | 1 | Active-low chip select |

## Verification
Each of the four write-length codes is run with a different read count. Checking the byte stream on the wire tells apart the address-order reversal, the two positions offset 7 can take and the read/write boundary. A slave model driving pseudo-random miso bits shows whether received bits are put together MSB first and land in the right receive slot. Rewriting registers and issuing a second start during a long transaction shows whether the frame was really latched and the start ignored. A start with the wrong key, writes to the read-only receive slots, and a one-byte read after a three-byte read show whether untouched state stays untouched.

// File: rtl/spi_cmd_pkg.sv
// Package: shared constants, register offsets and length decoding for the
// SPI command engine. Assumes 8-bit bytes and the fixed 1/2/4/5 write map.
package spi_cmd_pkg;

    localparam int BYTE_W    = 8;
    localparam int MAX_WR    = 5;
    localparam int MAX_RD    = 3;
    localparam int FRAME_W   = MAX_WR * BYTE_W;
    localparam int CNT_W     = $clog2(BYTE_W * (MAX_WR + MAX_RD) + 1);
    localparam int IDX_W     = $clog2(MAX_RD);
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    localparam logic [3:0] GO_KEY = 4'h5;

    localparam logic [2:0] OFS_CTRL    = 3'd0;
    localparam logic [2:0] OFS_CMD     = 3'd1;
    localparam logic [2:0] OFS_ADR_LO  = 3'd2;
    localparam logic [2:0] OFS_ADR_MID = 3'd3;
    localparam logic [2:0] OFS_ADR_HI  = 3'd4;
    localparam logic [2:0] OFS_RX0     = 3'd5;
    localparam logic [2:0] OFS_RX1     = 3'd6;
    localparam logic [2:0] OFS_DATA    = 3'd7;

    typedef logic [BYTE_W-1:0] byte_t;

    // Byte count selected by the two-bit write code.
    function automatic logic [2:0] wr_bytes(input logic [1:0] code);
        case (code)
            2'd0:    wr_bytes = 3'd1;
            2'd1:    wr_bytes = 3'd2;
            2'd2:    wr_bytes = 3'd4;
            default: wr_bytes = 3'd5;
        endcase
    endfunction

    // Bit count of the write phase.
    function automatic logic [CNT_W-1:0] wr_bits(input logic [1:0] code);
        wr_bits = CNT_W'(BYTE_W * int'(wr_bytes(code)));
    endfunction

    // Bit count of the read phase.
    function automatic logic [CNT_W-1:0] rd_bits(input logic [1:0] cnt);
        rd_bits = CNT_W'(BYTE_W * int'(cnt));
    endfunction

endpackage

// File: rtl/spi_cmd_regfile.sv
// Module: host register file. Holds the command, address and data bytes, the
// received bytes and the last accepted control nibble. Detects a valid start.
// Assumes reads are combinational and writes take effect at the clock edge.
module spi_cmd_regfile
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        ofs,
    input  byte_t             wr_data,
    output byte_t             rd_data,
    input  logic              busy,
    output logic              start,
    input  logic              rx_valid,
    input  logic [IDX_W-1:0]  rx_idx,
    input  byte_t             rx_byte,
    output byte_t             cmd_q,
    output byte_t             adr_hi_q,
    output byte_t             adr_mid_q,
    output byte_t             adr_lo_q,
    output byte_t             data_q
);

    logic [3:0] ctrl_q;
    byte_t      rx_q [MAX_RD];

    // Start request: keyed control write while the engine is idle.
    always_comb begin
        start = wr_en && (ofs == OFS_CTRL) && (wr_data[7:4] == GO_KEY) && !busy;
    end

    // Transmit-side byte registers, written at any time by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            adr_hi_q  <= '0;
            adr_mid_q <= '0;
            adr_lo_q  <= '0;
            data_q    <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_CMD:     cmd_q     <= wr_data;
                OFS_ADR_LO:  adr_lo_q  <= wr_data;
                OFS_ADR_MID: adr_mid_q <= wr_data;
                OFS_ADR_HI:  adr_hi_q  <= wr_data;
                OFS_DATA:    data_q    <= wr_data;
                default:     ;
            endcase
        end
    end

    // Control nibble of the last accepted start, shown in the status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (start) begin
            ctrl_q <= wr_data[3:0];
        end
    end

    // One receive register per reply slot, loaded when its byte completes.
    for (genvar gi = 0; gi < MAX_RD; gi++) begin : g_rx
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rx_q[gi] <= '0;
            end else if (rx_valid && (rx_idx == IDX_W'(gi))) begin
                rx_q[gi] <= rx_byte;
            end
        end
    end

    // Read multiplexer; offset 7 reads back the third received byte.
    always_comb begin
        case (ofs)
            OFS_CTRL:    rd_data = {busy, 3'b000, ctrl_q};
            OFS_CMD:     rd_data = cmd_q;
            OFS_ADR_LO:  rd_data = adr_lo_q;
            OFS_ADR_MID: rd_data = adr_mid_q;
            OFS_ADR_HI:  rd_data = adr_hi_q;
            OFS_RX0:     rd_data = rx_q[0];
            OFS_RX1:     rd_data = rx_q[1];
            default:     rd_data = rx_q[2];
        endcase
    end

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ofs == OFS_CTRL) && busy) |=> $stable(ctrl_q)); // R10

endmodule

// File: rtl/spi_cmd_framer.sv
// Module: assembles the left-aligned wire frame from the byte registers and
// the write code. Assumes unused tail positions are zero so that mosi is low
// during the read phase.
module spi_cmd_framer
    import spi_cmd_pkg::*;
(
    input  logic [1:0]         code,
    input  byte_t              cmd,
    input  byte_t              adr_hi,
    input  byte_t              adr_mid,
    input  byte_t              adr_lo,
    input  byte_t              data,
    output logic [FRAME_W-1:0] frame
);

    // Byte order per code: the address goes out high offset first.
    always_comb begin
        case (code)
            2'd0:    frame = {cmd, {(4*BYTE_W){1'b0}}};
            2'd1:    frame = {cmd, data, {(3*BYTE_W){1'b0}}};
            2'd2:    frame = {cmd, adr_hi, adr_mid, adr_lo, {BYTE_W{1'b0}}};
            default: frame = {cmd, adr_hi, adr_mid, adr_lo, data};
        endcase
    end

endmodule

// File: rtl/spi_cmd_clkgen.sv
// Module: half-period timer for sclk. Emits a one-cycle tick every HALF_DIV
// clocks while run is high; restarts from zero whenever run is low.
module spi_cmd_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] hcnt;

    // Phase boundary indication.
    always_comb begin
        tick = run && (hcnt == LAST);
    end

    // Half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + CW'(1);
        end
    end

    AST_HALF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (hcnt <= LAST)); // R8

endmodule

// File: rtl/spi_cmd_shifter.sv
// Module: bit engine. Latches the frame and lengths at start, drives sclk and
// mosi in mode 0, samples miso on rising sclk and reports completed reply
// bytes. Assumes tick marks each sclk phase boundary.
module spi_cmd_shifter
    import spi_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [1:0]         wr_code,
    input  logic [1:0]         rd_cnt,
    input  logic               tick,
    input  logic               miso,
    output logic               active,
    output logic               sclk,
    output logic               mosi,
    output logic               rx_valid,
    output logic [IDX_W-1:0]   rx_idx,
    output byte_t              rx_byte
);

    logic [FRAME_W-1:0] tx_sr;
    logic [CNT_W-1:0]   bit_q;
    logic [CNT_W-1:0]   wb_q;
    logic [CNT_W-1:0]   tot_q;
    logic [CNT_W-1:0]   rel;
    byte_t              rx_sr;
    logic               rise;
    logic               fall;
    logic               in_rd;
    logic               last;

    // Edge decode and reply-byte completion.
    always_comb begin
        rise     = active && tick && !sclk;
        fall     = active && tick && sclk;
        in_rd    = (bit_q >= wb_q);
        rel      = bit_q - wb_q;
        last     = (bit_q == (tot_q - CNT_W'(1)));
        rx_byte  = {rx_sr[BYTE_W-2:0], miso};
        rx_idx   = rel[BIT_IDX_W +: IDX_W];
        rx_valid = rise && in_rd && (rel[BIT_IDX_W-1:0] == {BIT_IDX_W{1'b1}});
    end

    // Transaction state: launch, rising-edge capture, falling-edge shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sclk   <= 1'b0;
            mosi   <= 1'b0;
            tx_sr  <= '0;
            bit_q  <= '0;
            wb_q   <= '0;
            tot_q  <= '0;
            rx_sr  <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            sclk   <= 1'b0;
            mosi   <= frame[FRAME_W-1];
            tx_sr  <= frame << 1;
            bit_q  <= '0;
            wb_q   <= wr_bits(wr_code);
            tot_q  <= wr_bits(wr_code) + rd_bits(rd_cnt);
            rx_sr  <= '0;
        end else if (rise) begin
            sclk <= 1'b1;
            if (in_rd) begin
                rx_sr <= rx_byte;
            end
        end else if (fall) begin
            sclk <= 1'b0;
            if (last) begin
                active <= 1'b0;
                mosi   <= 1'b0;
            end else begin
                bit_q <= bit_q + CNT_W'(1);
                mosi  <= tx_sr[FRAME_W-1];
                tx_sr <= tx_sr << 1;
            end
        end
    end

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sclk) |=> (!sclk || $stable(mosi))); // R8
    AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_q < tot_q)); // R9
    AST_RX_SLOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rel < (tot_q - wb_q))); // R7
    AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(sclk) && !sclk)); // R9

endmodule

// File: rtl/spi_cmd_engine.sv
// Module: top of the SPI command engine. Connects the register file, frame
// builder, sclk timer and bit engine. Assumes a single clock domain and an
// externally synchronised miso.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [2:0] reg_ofs,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n
);

    logic               busy;
    logic               start;
    logic               tick;
    logic               rx_valid;
    logic [IDX_W-1:0]   rx_idx;
    byte_t              rx_byte;
    byte_t              cmd_q;
    byte_t              adr_hi_q;
    byte_t              adr_mid_q;
    byte_t              adr_lo_q;
    byte_t              data_q;
    logic [FRAME_W-1:0] frame;

    spi_cmd_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .ofs       (reg_ofs),
        .wr_data   (reg_wdata),
        .rd_data   (reg_rdata),
        .busy      (busy),
        .start     (start),
        .rx_valid  (rx_valid),
        .rx_idx    (rx_idx),
        .rx_byte   (rx_byte),
        .cmd_q     (cmd_q),
        .adr_hi_q  (adr_hi_q),
        .adr_mid_q (adr_mid_q),
        .adr_lo_q  (adr_lo_q),
        .data_q    (data_q)
    );

    spi_cmd_framer u_frame (
        .code    (reg_wdata[1:0]),
        .cmd     (cmd_q),
        .adr_hi  (adr_hi_q),
        .adr_mid (adr_mid_q),
        .adr_lo  (adr_lo_q),
        .data    (data_q),
        .frame   (frame)
    );

    spi_cmd_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    spi_cmd_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame    (frame),
        .wr_code  (reg_wdata[1:0]),
        .rd_cnt   (reg_wdata[3:2]),
        .tick     (tick),
        .miso     (miso),
        .active   (busy),
        .sclk     (sclk),
        .mosi     (mosi),
        .rx_valid (rx_valid),
        .rx_idx   (rx_idx),
        .rx_byte  (rx_byte)
    );

    // Chip select follows the transaction window.
    always_comb begin
        cs_n = !busy;
    end

    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R8
    AST_CS_FALL_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !cs_n); // R9

endmodule

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_ofs = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       miso = 1'b0;
    wire  [7:0] reg_rdata;
    wire        sclk;
    wire        mosi;
    wire        cs_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    spi_cmd_engine #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .miso(miso),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- slave stimulus: pseudo-random miso ----------------
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso <= lfsr[15];
    end

    // ---------------- behavioural reference model ----------------
    bit         m_live = 1'b0;
    bit         m_act, m_sclk, m_mosi, m_was;
    int         m_h, m_pos, m_wb, m_tot;
    bit         m_tx[$];
    logic [7:0] m_cmd, m_a2, m_a3, m_a4, m_dat, m_acc;
    logic [7:0] m_rx[3];
    logic [3:0] m_ctrl;
    logic [7:0] m_bl[$];

    always @(posedge clk) begin
        m_live = 1'b1;
        if (!rst_n) begin
            m_act = 0; m_sclk = 0; m_mosi = 0; m_h = 0; m_pos = 0;
            m_cmd = 0; m_a2 = 0; m_a3 = 0; m_a4 = 0; m_dat = 0; m_acc = 0;
            m_rx[0] = 0; m_rx[1] = 0; m_rx[2] = 0; m_ctrl = 0;
        end else begin
            m_was = m_act;
            if (m_act) begin
                if (m_h == HALF - 1) begin
                    m_h = 0;
                    if (!m_sclk) begin
                        m_sclk = 1;
                        if (m_pos >= m_wb) begin
                            m_acc = {m_acc[6:0], miso};
                            if ((m_pos - m_wb) % 8 == 7) m_rx[(m_pos - m_wb) / 8] = m_acc;
                        end
                    end else begin
                        m_sclk = 0;
                        if (m_pos == m_tot - 1) begin
                            m_act = 0; m_mosi = 0;
                        end else begin
                            m_pos++;
                            m_mosi = (m_pos < m_wb) ? m_tx[m_pos] : 1'b0;
                        end
                    end
                end else begin
                    m_h++;
                end
            end
            if (reg_wr) begin
                case (reg_ofs)
                    3'd1: m_cmd = reg_wdata;
                    3'd2: m_a2  = reg_wdata;
                    3'd3: m_a3  = reg_wdata;
                    3'd4: m_a4  = reg_wdata;
                    3'd7: m_dat = reg_wdata;
                    3'd0: if (!m_was && reg_wdata[7:4] == 4'h5) begin
                        m_bl = {m_cmd};
                        if (reg_wdata[1:0] == 2'd1) m_bl.push_back(m_dat);
                        if (reg_wdata[1:0] >= 2'd2) begin
                            m_bl.push_back(m_a4); m_bl.push_back(m_a3); m_bl.push_back(m_a2);
                        end
                        if (reg_wdata[1:0] == 2'd3) m_bl.push_back(m_dat);
                        m_tx.delete();
                        foreach (m_bl[k]) for (int b = 7; b >= 0; b--) m_tx.push_back(m_bl[k][b]);
                        m_wb = m_tx.size();
                        m_tot = m_wb + 8 * int'(reg_wdata[3:2]);
                        m_act = 1; m_sclk = 0; m_h = 0; m_pos = 0; m_acc = 0;
                        m_mosi = m_tx[0];
                        m_ctrl = reg_wdata[3:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] m_read(input logic [2:0] o);
        case (o)
            3'd0: return {m_act, 3'b000, m_ctrl};
            3'd1: return m_cmd;
            3'd2: return m_a2;
            3'd3: return m_a3;
            3'd4: return m_a4;
            3'd5: return m_rx[0];
            3'd6: return m_rx[1];
            default: return m_rx[2];
        endcase
    endfunction

    // Every-clock comparison, sampled 1.5 ns after the rising edge.
    always @(posedge clk) begin
        #1.5;
        if (m_live && !done) begin
            chk("R9 cs_n vs model", cs_n, !m_act);
            chk("R8 sclk vs model", sclk, m_sclk);
            chk("R4/R5/R6 mosi vs model", mosi, m_mosi);
            case (reg_ofs)
                3'd0:          chk("R11 status vs model", reg_rdata, m_read(reg_ofs));
                3'd5, 3'd6, 3'd7: chk("R7 rx reg vs model", reg_rdata, m_read(reg_ofs));
                default:       chk("R10 byte reg vs model", reg_rdata, m_read(reg_ofs));
            endcase
        end
    end

    // ---------------- wire sniffer ----------------
    int         sn_n = 0;
    logic [7:0] sn_o, sn_i;
    logic [7:0] sn_mo[$];
    logic [7:0] sn_mi[$];
    always @(posedge sclk) begin
        sn_o = {sn_o[6:0], mosi};
        sn_i = {sn_i[6:0], miso};
        sn_n++;
        if (sn_n % 8 == 0) begin
            sn_mo.push_back(sn_o);
            sn_mi.push_back(sn_i);
        end
    end

    // ---------------- host tasks ----------------
    logic [7:0] s_cmd = 0, s_a2 = 0, s_a3 = 0, s_a4 = 0, s_dat = 0;

    task automatic wr(input logic [2:0] o, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_ofs = o; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] o, output logic [7:0] v);
        reg_ofs = o;
        #1;
        v = reg_rdata;
    endtask

    task automatic load(input logic [7:0] c, a2, a3, a4, d);
        wr(3'd1, c); wr(3'd2, a2); wr(3'd3, a3); wr(3'd4, a4); wr(3'd7, d);
        s_cmd = c; s_a2 = a2; s_a3 = a3; s_a4 = a4; s_dat = d;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int guard = 0;
        do begin
            @(negedge clk);
            rd(3'd0, v);
            guard++;
        end while (v[7] && guard < 5000);
        if (guard >= 5000) chk("R9 transaction ends", 1, 0);
    endtask

    // Start one transaction and check wire bytes, edge count and reply slots.
    task automatic xact(input logic [1:0] code, input logic [1:0] rdc, input string tag);
        logic [7:0] exp[$];
        logic [7:0] v;
        sn_mo.delete(); sn_mi.delete(); sn_n = 0;
        exp = {s_cmd};
        if (code == 2'd1) exp.push_back(s_dat);
        if (code >= 2'd2) begin exp.push_back(s_a4); exp.push_back(s_a3); exp.push_back(s_a2); end
        if (code == 2'd3) exp.push_back(s_dat);
        wr(3'd0, {4'h5, rdc, code});
        rd(3'd0, v);
        chk({"R2 busy after start ", tag}, v, {1'b1, 3'b000, rdc, code});
        chk("R9 cs_n low during transaction", cs_n, 0);
        wait_idle();
        chk({"R9 sclk rising edges ", tag}, sn_n, 8 * (exp.size() + rdc));
        chk({"R3 bytes sent ", tag}, sn_mo.size(), exp.size() + rdc);
        foreach (exp[k]) chk({"R4/R5/R6 wire byte ", tag}, sn_mo[k], exp[k]);
        for (int k = 0; k < rdc; k++) begin
            rd(3'd5 + 3'(k), v);
            chk({"R7 reply slot ", tag}, v, sn_mi[exp.size() + k]);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] v;
        logic [7:0] keep6, keep7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        chk("R1 cs_n reset", cs_n, 1);
        chk("R1 sclk reset", sclk, 0);
        chk("R1 mosi reset", mosi, 0);
        for (int o = 0; o < 8; o++) begin
            rd(3'(o), v);
            chk("R1 register reset value", v, 0);
        end

        load(8'h9F, 8'h11, 8'h22, 8'h33, 8'hA5);
        xact(2'd0, 2'd3, "code0 rd3");      // R3 R4 R7
        xact(2'd1, 2'd0, "code1 rd0");      // R6
        xact(2'd2, 2'd2, "code2 rd2");      // R5
        load(8'h02, 8'hC3, 8'h5A, 8'h81, 8'h7E);
        xact(2'd3, 2'd1, "code3 rd1");      // R5 R6

        // R7: a one-byte read leaves slots 6 and 7 untouched
        xact(2'd0, 2'd3, "refill rd3");
        rd(3'd6, keep6); rd(3'd7, keep7);
        xact(2'd1, 2'd1, "code1 rd1");
        rd(3'd6, v); chk("R7 slot 6 kept", v, keep6);
        rd(3'd7, v); chk("R7 slot 7 kept", v, keep7);

        // R2: wrong key starts nothing
        wr(3'd0, 8'h4B);
        repeat (6) @(negedge clk);
        chk("R2 no start on wrong key cs_n", cs_n, 1);
        rd(3'd0, v);
        chk("R2 status after wrong key", v, {4'h0, 2'd1, 2'd1});

        // R10: writes and a second start during a transaction
        sn_mo.delete(); sn_mi.delete(); sn_n = 0;
        wr(3'd0, {4'h5, 2'd2, 2'd3});
        wr(3'd1, 8'h00); wr(3'd4, 8'h00); wr(3'd2, 8'hFF); wr(3'd7, 8'h00);
        wr(3'd0, 8'h50);
        rd(3'd0, v);
        chk("R10 start while busy ignored", v, {1'b1, 3'b000, 2'd2, 2'd3});
        wait_idle();
        chk("R10 edge count unchanged", sn_n, 8 * 7);
        chk("R10 latched cmd", sn_mo[0], 8'h02);
        chk("R10 latched adr hi", sn_mo[1], 8'h81);
        chk("R10 latched adr lo", sn_mo[3], 8'hC3);
        chk("R10 latched data", sn_mo[4], 8'h7E);
        rd(3'd1, v); chk("R10 register took new value", v, 8'h00);
        s_cmd = 8'h00; s_a4 = 8'h00; s_a2 = 8'hFF; s_dat = 8'h00;

        // R11: writes to receive slots 5 and 6 are ignored
        rd(3'd5, keep6);
        wr(3'd5, 8'hEE); wr(3'd6, 8'hDD);
        rd(3'd5, v); chk("R11 write to slot 5 ignored", v, keep6);
        rd(3'd6, v); chk("R11 write to slot 6 ignored", v, sn_mi[6]);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule